// File: doc/BRIEF.md
# SM3 Iterative Compression Core

This block keeps the 256-bit SM3 chaining value as eight 32-bit words and runs the 64-round SM3 compression function over one 512-bit message block at a time. It executes one round per clock. A separate expansion unit supplies the two per-round message words: the plain word W and the mixed word W' = W(j) ^ W(j+4). The core shows the index of the round it is executing on `round_o`, so the expansion unit can present the matching pair in that same cycle. The round constant is produced inside the core.

A message is hashed as follows. The caller pulses `init_i` to load the standard initial value. It then issues one `start_i` per block and waits for `done_o`. When a block finishes, the chaining value is replaced by its old value XORed with the eight working registers. The next block starts from that result, so the blocks of a long message chain until the caller initialises again. Padding, length encoding and message expansion are done outside this block.

Top module: `sm3_compress_core`

## Requirements
- R1: During and after synchronous reset, `busy_o` and `done_o` are low. `digest_o` holds the initial value 7380166F 4914B2B9 172442D7 DA8A0600 A96F30BC 163138AA E38DEE4D B0FB0E4E, with the first word in bits 255:224.
- R2: `init_i` sampled while idle loads the initial value into `digest_o` on the next cycle. `init_i` is ignored while busy. If `init_i` and `start_i` are sampled together while idle, the block starts from the initial value.
- R3: `start_i` sampled while idle raises `busy_o` on the next cycle with `round_o` = 0. `round_o` then advances by one each cycle up to 63. In each of those cycles, `w_i` and `wp_i` are consumed for the round shown.
- R4: Rounds 0 to 15 use x^y^z for both boolean functions. Rounds 16 to 63 use majority (x&y)|(x&z)|(y&z) on A,B,C and choose (x&y)|(~x&z) on E,F,G.
- R5: The constant of round j is T rotated left by (j mod 32), where T is 79CC4519 for j < 16 and 7A879D8A otherwise.
- R6: Each round computes SS1, SS2, TT1 and TT2 modulo 2^32. It then shifts the registers, rotating B left by 9 and F left by 19, and applies P0(x) = x ^ rotl(x,9) ^ rotl(x,17) to the new E. After round 63 each chaining word becomes its old value XOR the matching working register.
- R7: `busy_o` stays high for 65 cycles per block. `done_o` is high for exactly one cycle, the first idle cycle, and in that cycle `digest_o` already holds the new chaining value.
- R8: `start_i` sampled while busy is ignored. A `start_i` sampled in the `done_o` cycle begins the next block from the chaining value just produced.
- R9: The single padded block of the message "abc" yields digest 66C7F0F4 62EEEDD9 D1F2D46B DC10E4E2 4167C487 5CF2F7A2 297DA02B 8F4BA8E0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Load the initial chaining value (idle only) |
| start_i | input | 1 | Begin compressing one block (idle only) |
| w_i | input | 32 | Expanded word W for the round shown on `round_o` |
| wp_i | input | 32 | Mixed word W' for the round shown on `round_o` |
| busy_o | output | 1 | Core is running rounds or folding |
| done_o | output | 1 | One-cycle pulse: block finished, digest updated |
| round_o | output | 6 | Index of the round being executed |
| digest_o | output | 256 | Chaining value, first word in the top bits |

## Verification
The assertions assume only that `rst` is held for at least one clock. They place no limit on when `init_i` or `start_i` may rise, because the core itself must discard those while busy. They cannot check that `wp_i` really equals W(j)^W(j+4), since the core trusts the expansion unit for that. The stimulus therefore derives both words from its own expansion of each block and drives them according to its own count of cycles since start, not from `round_o`. It deliberately pulses `init_i` and `start_i` in the middle of a block, asserts both together while idle, and issues a fresh start exactly in the `done_o` cycle, so every control path is exercised within those assumptions.

// File: rtl/sm3_pkg.sv
package sm3_pkg;
  localparam int WORD_W       = 32;
  localparam int NUM_WORDS    = 8;
  localparam int ROUNDS       = 64;
  localparam int SWITCH_ROUND = 16;
  localparam int RND_W        = $clog2(ROUNDS);
  localparam int STATE_W      = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  // Field a sits in the top bits so the struct lines up with the digest order.
  typedef struct packed {
    word_t a; word_t b; word_t c; word_t d;
    word_t e; word_t f; word_t g; word_t h;
  } regs_t;

  localparam logic [STATE_W-1:0] IV_VEC = {
    32'h7380166F, 32'h4914B2B9, 32'h172442D7, 32'hDA8A0600,
    32'hA96F30BC, 32'h163138AA, 32'hE38DEE4D, 32'hB0FB0E4E};

  localparam word_t T_LOW  = 32'h79CC4519;
  localparam word_t T_HIGH = 32'h7A879D8A;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << (n % WORD_W);
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t perm0(input word_t x);
    return x ^ rotl(x, 9) ^ rotl(x, 17);
  endfunction

  function automatic word_t bool_ff(input word_t x, input word_t y, input word_t z,
                                    input logic hi);
    return hi ? ((x & y) | (x & z) | (y & z)) : (x ^ y ^ z);
  endfunction

  function automatic word_t bool_gg(input word_t x, input word_t y, input word_t z,
                                    input logic hi);
    return hi ? ((x & y) | (~x & z)) : (x ^ y ^ z);
  endfunction
endpackage

// File: rtl/sm3_kgen.sv
module sm3_kgen
  import sm3_pkg::*;
#(
  parameter int NR     = ROUNDS,
  parameter int SWITCH = SWITCH_ROUND,
  localparam int RW    = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [RW-1:0] round_i,
  output word_t         k_o
);
  localparam word_t K_AT_SWITCH = rotl(T_HIGH, SWITCH);

  word_t k_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q <= T_LOW;
    end else if (load_i) begin
      k_q <= T_LOW;
    end else if (step_i) begin
      if (round_i == RW'(SWITCH - 1)) k_q <= K_AT_SWITCH;
      else                            k_q <= rotl(k_q, 1);
    end
  end

  assign k_o = k_q;

  AST_K_RESTART: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (k_o == T_LOW)); // R5
endmodule

// File: rtl/sm3_round.sv
module sm3_round
  import sm3_pkg::*;
(
  input  regs_t cur_i,
  input  word_t w_i,
  input  word_t wp_i,
  input  word_t k_i,
  input  logic  hi_i,
  output regs_t nxt_o
);
  word_t a12, ss1, ss2, tt1, tt2;

  always_comb begin
    a12 = rotl(cur_i.a, 12);
    ss1 = rotl(a12 + cur_i.e + k_i, 7);
    ss2 = ss1 ^ a12;
    tt1 = bool_ff(cur_i.a, cur_i.b, cur_i.c, hi_i) + cur_i.d + ss2 + wp_i;
    tt2 = bool_gg(cur_i.e, cur_i.f, cur_i.g, hi_i) + cur_i.h + ss1 + w_i;
    nxt_o.a = tt1;
    nxt_o.b = cur_i.a;
    nxt_o.c = rotl(cur_i.b, 9);
    nxt_o.d = cur_i.c;
    nxt_o.e = perm0(tt2);
    nxt_o.f = cur_i.e;
    nxt_o.g = rotl(cur_i.f, 19);
    nxt_o.h = cur_i.g;
  end
endmodule

// File: rtl/sm3_chain.sv
module sm3_chain
  import sm3_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  init_i,
  input  logic  fold_i,
  input  regs_t work_i,
  output regs_t chain_o
);
  regs_t chain_q;

  always_ff @(posedge clk) begin
    if (rst || init_i) chain_q <= regs_t'(IV_VEC);
    else if (fold_i)   chain_q <= chain_q ^ work_i;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/sm3_compress_core.sv
module sm3_compress_core
  import sm3_pkg::*;
#(
  parameter int NR     = ROUNDS,
  parameter int SWITCH = SWITCH_ROUND,
  localparam int RW    = $clog2(NR)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init_i,
  input  logic           start_i,
  input  logic [31:0]    w_i,
  input  logic [31:0]    wp_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [RW-1:0]  round_o,
  output logic [255:0]   digest_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} phase_t;

  phase_t        phase_q;
  logic [RW-1:0] rnd_q;
  regs_t         work_q, work_nxt, chain;
  word_t         k_cur;
  logic          busy_q, done_q;
  logic          idle, start_fire, init_fire, run, fold;

  assign idle       = (phase_q == ST_IDLE);
  assign start_fire = idle && start_i;
  assign init_fire  = idle && init_i;
  assign run        = (phase_q == ST_RUN);
  assign fold       = (phase_q == ST_FOLD);

  sm3_kgen #(.NR(NR), .SWITCH(SWITCH)) u_kgen (
    .clk(clk), .rst(rst), .load_i(start_fire), .step_i(run),
    .round_i(rnd_q), .k_o(k_cur));

  sm3_round u_round (
    .cur_i(work_q), .w_i(w_i), .wp_i(wp_i), .k_i(k_cur),
    .hi_i(rnd_q >= RW'(SWITCH)), .nxt_o(work_nxt));

  sm3_chain u_chain (
    .clk(clk), .rst(rst), .init_i(init_fire), .fold_i(fold),
    .work_i(work_q), .chain_o(chain));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ST_IDLE;
      rnd_q   <= '0;
      work_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        ST_IDLE: if (start_i) begin
          phase_q <= ST_RUN;
          rnd_q   <= '0;
          busy_q  <= 1'b1;
          work_q  <= init_i ? regs_t'(IV_VEC) : chain;
        end
        ST_RUN: begin
          work_q <= work_nxt;
          if (rnd_q == RW'(NR - 1)) phase_q <= ST_FOLD;
          else                      rnd_q   <= rnd_q + RW'(1);
        end
        ST_FOLD: begin
          phase_q <= ST_IDLE;
          rnd_q   <= '0;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign round_o  = rnd_q;
  assign digest_o = chain;

  AST_INIT_LOADS_IV: assert property (@(posedge clk) disable iff (rst)
    (init_i && !busy_o) |=> (digest_o == IV_VEC)); // R2
  AST_RUN_HOLDS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(digest_o)); // R2
  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && round_o == '0)); // R3
  AST_ROUND_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (run && rnd_q != RW'(NR - 1)) |=> (round_o == RW'($past(round_o) + RW'(1)))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !fold) |=> busy_o); // R8
endmodule

// File: tb/sm3_compress_core_bench.sv
module sm3_compress_core_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init_i = 1'b0, start_i = 1'b0;
  logic [31:0]  w_i = '0, wp_i = '0;
  logic         busy_o, done_o;
  logic [5:0]   round_o;
  logic [255:0] digest_o;

  always #2.5 clk = ~clk;

  sm3_compress_core u_sm3_compress_core (
    .clk(clk), .rst(rst), .init_i(init_i), .start_i(start_i),
    .w_i(w_i), .wp_i(wp_i), .busy_o(busy_o), .done_o(done_o),
    .round_o(round_o), .digest_o(digest_o));

  localparam logic [255:0] IV = 256'h7380166F4914B2B9172442D7DA8A0600A96F30BC163138AAE38DEE4DB0FB0E4E;
  localparam logic [255:0] ABC_DIGEST = 256'h66C7F0F462EEEDD9D1F2D46BDC10E4E24167C4875CF2F7A2297DA02B8F4BA8E0;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [31:0] blk [16];
  logic [31:0] wx [68];
  logic        m_busy = 1'b0, m_done = 1'b0;
  int          m_cnt = 0;
  logic [255:0] m_chain = IV, m_result = '0;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    if (n % 32 == 0) return x;
    return (x << (n % 32)) | (x >> (32 - n % 32));
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] v);
    logic [31:0] r [8];
    logic [31:0] ss1, ss2, t1, t2, f1, g1, tc;
    for (int i = 0; i < 8; i++) r[i] = v[255-32*i -: 32];
    for (int j = 0; j < 64; j++) begin
      tc  = rl(j < 16 ? 32'h79CC4519 : 32'h7A879D8A, j);
      ss1 = rl(rl(r[0], 12) + r[4] + tc, 7);
      ss2 = ss1 ^ rl(r[0], 12);
      if (j < 16) begin
        f1 = r[0] ^ r[1] ^ r[2];
        g1 = r[4] ^ r[5] ^ r[6];
      end else begin
        f1 = (r[0] & r[1]) | (r[0] & r[2]) | (r[1] & r[2]);
        g1 = (r[4] & r[5]) | (~r[4] & r[6]);
      end
      t1 = f1 + r[3] + ss2 + (wx[j] ^ wx[j+4]);
      t2 = g1 + r[7] + ss1 + wx[j];
      r[3] = r[2]; r[2] = rl(r[1], 9); r[1] = r[0]; r[0] = t1;
      r[7] = r[6]; r[6] = rl(r[5], 19); r[5] = r[4];
      r[4] = t2 ^ rl(t2, 9) ^ rl(t2, 17);
    end
    for (int i = 0; i < 8; i++) v[255-32*i -: 32] ^= r[i];
    return v;
  endfunction

  task automatic expand();
    logic [31:0] q;
    for (int j = 0; j < 16; j++) wx[j] = blk[j];
    for (int j = 16; j < 68; j++) begin
      q = wx[j-16] ^ wx[j-9] ^ rl(wx[j-3], 15);
      wx[j] = q ^ rl(q, 15) ^ rl(q, 23) ^ rl(wx[j-13], 7) ^ wx[j-6];
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(busy_o == m_busy, "R7", "busy", 256'(busy_o), 256'(m_busy));
    check(done_o == m_done, "R7", "done", 256'(done_o), 256'(m_done));
    check(digest_o == m_chain, "R6", "digest", digest_o, m_chain);
    if (m_busy && m_cnt < 64)
      check(round_o == 6'(m_cnt), "R3", "round", 256'(round_o), 256'(m_cnt));
  endtask

  task automatic drive_words();
    if (m_busy && m_cnt < 64) begin
      w_i  = wx[m_cnt];
      wp_i = wx[m_cnt] ^ wx[m_cnt+4];
    end else begin
      w_i  = $urandom;
      wp_i = $urandom;
    end
  endtask

  // One clock: model next state from current inputs, edge, compare at negedge.
  task automatic tick();
    logic n_busy, n_done;
    int n_cnt;
    logic [255:0] n_chain;
    n_busy = m_busy; n_done = 1'b0; n_cnt = m_cnt; n_chain = m_chain;
    if (!m_busy) begin
      if (init_i) n_chain = IV;
      if (start_i) begin
        expand();
        m_result = compress(init_i ? IV : m_chain);
        n_busy = 1'b1; n_cnt = 0;
      end
    end else if (m_cnt < 64) begin
      n_cnt = m_cnt + 1;
    end else begin
      n_chain = m_result; n_busy = 1'b0; n_done = 1'b1; n_cnt = 0;
    end
    drive_words();
    @(posedge clk);
    m_busy = n_busy; m_done = n_done; m_cnt = n_cnt; m_chain = n_chain;
    @(negedge clk);
    compare_all();
    drive_words();
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  endtask

  task automatic run_block();
    start_i = 1'b1; tick(); start_i = 1'b0;
    repeat (65) tick();
  endtask

  task automatic random_block();
    for (int i = 0; i < 16; i++) blk[i] = $urandom;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();                       // R1 reset state
    rst = 1'b0;
    tick(); tick();                      // R1 idle after reset

    // R9: the padded "abc" block
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 32'h61626380; blk[15] = 32'h00000018;
    run_block();
    check(done_o && digest_o == ABC_DIGEST, "R9", "abc digest", digest_o, ABC_DIGEST);

    // R8: start from the done cycle chains onto the previous result (R4, R5, R6)
    random_block();
    run_block();
    random_block();
    run_block();

    // R2/R8: init and start pulses during a block are ignored
    random_block();
    start_i = 1'b1; tick(); start_i = 1'b0;
    for (int c = 0; c < 65; c++) begin
      init_i  = (c == 10);
      start_i = (c == 40);
      tick();
    end
    init_i = 1'b0; start_i = 1'b0;
    tick();

    // R2: init alone restores the initial value
    init_i = 1'b1; tick(); init_i = 1'b0;
    check(digest_o == IV, "R2", "init value", digest_o, IV);

    // R2: init and start together start from the initial value
    random_block();
    run_block();
    random_block();
    init_i = 1'b1; start_i = 1'b1; tick(); init_i = 1'b0; start_i = 1'b0;
    repeat (65) tick();
    repeat (3) tick();

    // R4 boundary: all-zero and all-ones blocks
    init_i = 1'b1; tick(); init_i = 1'b0;
    for (int i = 0; i < 16; i++) blk[i] = '0;
    run_block();
    for (int i = 0; i < 16; i++) blk[i] = '1;
    run_block();
    tick();

    // R1: reset mid-block returns to the initial state
    random_block();
    start_i = 1'b1; tick(); start_i = 1'b0;
    repeat (20) tick();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_chain = IV;
    compare_all();
    rst = 1'b0;
    tick();

    finish_run();
  end
endmodule